// File: doc/BRIEF.md
# State-Sequenced Event Timer

This block is a counter-based timer whose events are qualified by a small state register that persists across counter periods. Each event watches one match comparator and one I/O line (any block input or any block output), combines them in one of four ways, and is allowed to fire only in the states its mask enables. It can also be restricted to one count direction. A fired event can set, clear or toggle outputs, pulse the interrupt or DMA request lines, load a new state, and limit, halt, stop or restart the counter.

The counter counts upwards and wraps, or counts up and down and reverses at its limit. The limit comes from a limit event or, when automatic limiting is enabled, from a hit on match register 0. A match event can be held pending until its I/O condition arrives. All configuration is written through a single-cycle write port (`cfgWe`, `cfgAddr`, `cfgData`). After reset the counter is stopped, so the block can be configured before it is started.

Top module: `sevt_timer`

## Requirements
- R1: After reset `count` is 0, `ioOut`, `irq`, `dmaReq` and `stateOut` are 0, `countDown` is 0, and the counter stays stopped until a control write at address 0x00 clears bit 3. In that register, bit 0 selects up-down mode, bit 1 enables automatic limiting, bit 2 writes the halt flag, bit 3 writes the stop flag, and a 1 in bit 4 clears the count to 0 with direction up.
- R2: In up mode with automatic limiting enabled, the count runs 0,1,…,M0 and then returns to 0, where M0 is the match value at address 0x10.
- R3: In up-down mode, the count climbs to the limit, then descends to 0, then climbs again. `countDown` is 1 while it descends.
- R4: An event whose bit is set in the limit mask (address 0x02) wraps the counter on its fire. With automatic limiting off, a hit on match register 0 does not limit. Match registers are at 0x10+m.
- R5: An event fires only when bit `stateOut` of its state mask is set. Event configuration is at 0x20+e: bits 3:0 match select, 7:4 I/O select (inputs first, then outputs), 8 required I/O level, 10:9 mode, 12:11 direction, 13 hold, 14 state load, 18:16 next state, 31:24 state mask. A fired event with bit 14 set loads its next state. Address 0x01 writes the state directly.
- R6: When several state-loading events fire in one cycle, the lowest-numbered one supplies the new state.
- R7: Direction field 1 allows firing only while counting up, 2 only while counting down, and 0 or 3 in both directions.
- R8: Mode 0 fires on the match alone, 1 on the I/O level alone, 2 on match AND I/O level, and 3 on match OR I/O level. Match hits count only while the counter runs.
- R9: In AND mode with hold set, a qualified match that arrives without its I/O level is kept pending. The event fires in the first cycle the I/O level holds, and the fire clears the pending flag. Without hold, that match is lost.
- R10: Halt mask (0x03) events freeze the counter, and a start event cannot undo the freeze. Halt takes priority over stop and start in the same cycle and is cleared only by a control write.
- R11: Stop mask (0x04) events freeze the counter and start mask (0x05) events resume it. Stop wins over start in the same cycle.
- R12: Output o is configured at 0x30+o with the set mask in bits 15:0 and the clear mask in bits 31:16. Set drives it to 1, clear drives it to 0, and both together toggle it, one cycle after the fire.
- R13: `irq` and `dmaReq` pulse one cycle after a fire of any event enabled in the interrupt mask (0x06) or the DMA mask (0x07).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration register address |
| cfgData | input | 32 | Configuration write data |
| ioIn | input | NUM_IN | Event condition inputs |
| ioOut | output | NUM_OUT | Event-driven outputs |
| irq | output | 1 | Interrupt request pulse |
| dmaReq | output | 1 | DMA request pulse |
| count | output | CNT_W | Current counter value |
| countDown | output | 1 | Counter is descending |
| stateOut | output | STATE_W | Current state variable |

## Verification
The hardest situation to reach is the held match. A match must occur while its I/O level is absent, and the level must then appear only after the counter has moved past the match value, so the fire can come only from the pending flag. The stimulus starts the counter with a clearing control write, which makes the count a known function of elapsed cycles. It then raises the input at a chosen count after the match, and repeats the sequence without hold to show the fire vanishes. Same-cycle halt, stop and start conflicts are reached by tying all three control masks to one I/O-only event.

// File: rtl/sevt_pkg.sv
package sevt_pkg;

  typedef enum logic [1:0] {
    MODE_MATCH = 2'd0,
    MODE_IO    = 2'd1,
    MODE_AND   = 2'd2,
    MODE_OR    = 2'd3
  } combMode_e;

  typedef enum logic [1:0] {
    DIR_ANY  = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2,
    DIR_BOTH = 2'd3
  } dirQual_e;

  typedef struct packed {
    logic [7:0] stateMask;
    logic [4:0] spare1;
    logic [2:0] nextState;
    logic       spare0;
    logic       loadState;
    logic       holdMatch;
    dirQual_e   dirQual;
    combMode_e  mode;
    logic       ioLevel;
    logic [3:0] ioSel;
    logic [3:0] matchSel;
  } evCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCnt;
    logic run;
    logic upDown;
    logic autoLimit;
    logic limitEv;
  } cntStrobe_t;

  localparam logic [7:0] ADDR_CTRL  = 8'h00;
  localparam logic [7:0] ADDR_STATE = 8'h01;
  localparam logic [7:0] ADDR_LIMIT = 8'h02;
  localparam logic [7:0] ADDR_HALT  = 8'h03;
  localparam logic [7:0] ADDR_STOP  = 8'h04;
  localparam logic [7:0] ADDR_START = 8'h05;
  localparam logic [7:0] ADDR_IRQ   = 8'h06;
  localparam logic [7:0] ADDR_DMA   = 8'h07;
  localparam logic [3:0] PAGE_MATCH = 4'h1;
  localparam logic [3:0] PAGE_EVENT = 4'h2;
  localparam logic [3:0] PAGE_OUT   = 4'h3;

endpackage

// File: rtl/sevt_datapath.sv
module sevt_datapath
  import sevt_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int NUM_MATCH = 4
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  cntStrobe_t                          strb,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0]     matchVals,
  output logic [NUM_MATCH-1:0]                matchHit,
  output logic [CNT_W-1:0]                    count,
  output logic                                countDown
);

  logic limitNow;

  for (genvar m = 0; m < NUM_MATCH; m++) begin : g_cmp
    assign matchHit[m] = (count == matchVals[m]);
  end

  assign limitNow = strb.run && (strb.limitEv || (strb.autoLimit && matchHit[0]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= '0;
      countDown <= 1'b0;
    end else if (strb.clearCnt) begin
      count     <= '0;
      countDown <= 1'b0;
    end else if (strb.run) begin
      if (!strb.upDown) begin
        countDown <= 1'b0;
        count     <= limitNow ? '0 : count + 1'b1;
      end else if (countDown) begin
        if (count == '0) begin
          countDown <= 1'b0;
          count     <= count + 1'b1;
        end else begin
          count <= count - 1'b1;
        end
      end else if (limitNow) begin
        countDown <= 1'b1;
        count     <= count - 1'b1;
      end else begin
        count <= count + 1'b1;
      end
    end
  end

  // R10
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.clearCnt) |=> $stable(count));

  // R3
  descend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.upDown && !strb.clearCnt && countDown && count != '0) |=> countDown);

endmodule

// File: rtl/sevt_ctrl.sv
module sevt_ctrl
  import sevt_pkg::*;
#(
  parameter int NUM_EVENTS = 4,
  parameter int NUM_MATCH  = 4,
  parameter int NUM_IN     = 4,
  parameter int NUM_OUT    = 4,
  parameter int CNT_W      = 16,
  parameter int STATE_W    = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cfgWe,
  input  logic [7:0]                        cfgAddr,
  input  logic [31:0]                       cfgData,
  input  logic [NUM_IN-1:0]                 ioIn,
  input  logic                              countDown,
  input  logic [NUM_MATCH-1:0]              matchHit,
  output cntStrobe_t                        strb,
  output logic [NUM_MATCH-1:0][CNT_W-1:0]   matchVals,
  output logic [NUM_OUT-1:0]                ioOut,
  output logic                              irq,
  output logic                              dmaReq,
  output logic [STATE_W-1:0]                stateOut
);

  localparam int IO_W = NUM_IN + NUM_OUT;

  logic upDownQ, autoLimQ, haltQ, stopQ;
  logic [STATE_W-1:0] stateQ, stateNext;
  logic [NUM_EVENTS-1:0] limitMask, haltMask, stopMask, startMask, irqMask, dmaMask;
  logic [NUM_MATCH-1:0][CNT_W-1:0] matchQ;
  evCfg_t evCfg [NUM_EVENTS];
  logic [NUM_EVENTS-1:0] setMask [NUM_OUT];
  logic [NUM_EVENTS-1:0] clrMask [NUM_OUT];
  logic [NUM_EVENTS-1:0] fired, pendQ, pendD;
  logic [NUM_OUT-1:0] ioOutQ, setHit, clrHit;
  logic [NUM_MATCH-1:0] gatedHit;
  logic [IO_W-1:0] ioAll;
  logic runNow, wrCtrl, wrState, loadAny;
  logic haltFire, stopFire, startFire;
  logic unusedSpare;

  assign wrCtrl   = cfgWe && (cfgAddr == ADDR_CTRL);
  assign wrState  = cfgWe && (cfgAddr == ADDR_STATE);
  assign runNow   = !haltQ && !stopQ;
  assign gatedHit = matchHit & {NUM_MATCH{runNow}};
  assign ioAll    = {ioOutQ, ioIn};

  // configuration bank
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upDownQ <= 1'b0; autoLimQ <= 1'b0;
      limitMask <= '0; haltMask <= '0; stopMask <= '0;
      startMask <= '0; irqMask <= '0; dmaMask <= '0;
      matchQ <= '0;
      for (int e = 0; e < NUM_EVENTS; e++) evCfg[e] <= '0;
      for (int o = 0; o < NUM_OUT; o++) begin
        setMask[o] <= '0;
        clrMask[o] <= '0;
      end
    end else if (cfgWe) begin
      case (cfgAddr)
        ADDR_CTRL:  begin upDownQ <= cfgData[0]; autoLimQ <= cfgData[1]; end
        ADDR_LIMIT: limitMask <= cfgData[NUM_EVENTS-1:0];
        ADDR_HALT:  haltMask  <= cfgData[NUM_EVENTS-1:0];
        ADDR_STOP:  stopMask  <= cfgData[NUM_EVENTS-1:0];
        ADDR_START: startMask <= cfgData[NUM_EVENTS-1:0];
        ADDR_IRQ:   irqMask   <= cfgData[NUM_EVENTS-1:0];
        ADDR_DMA:   dmaMask   <= cfgData[NUM_EVENTS-1:0];
        default: ;
      endcase
      for (int m = 0; m < NUM_MATCH; m++)
        if (cfgAddr == {PAGE_MATCH, 4'(m)}) matchQ[m] <= cfgData[CNT_W-1:0];
      for (int e = 0; e < NUM_EVENTS; e++)
        if (cfgAddr == {PAGE_EVENT, 4'(e)}) evCfg[e] <= evCfg_t'(cfgData);
      for (int o = 0; o < NUM_OUT; o++)
        if (cfgAddr == {PAGE_OUT, 4'(o)}) begin
          setMask[o] <= cfgData[NUM_EVENTS-1:0];
          clrMask[o] <= cfgData[16+NUM_EVENTS-1:16];
        end
    end
  end

  // event evaluation
  always_comb begin
    evCfg_t cfg;
    logic [NUM_MATCH-1:0] hitSh;
    logic [IO_W-1:0] ioSh;
    logic [7:0] smSh;
    logic mHit, ioOk, dirOk, qual, holdOn, anyHit, cond;
    fired = '0;
    pendD = '0;
    unusedSpare = 1'b0;
    for (int e = 0; e < NUM_EVENTS; e++) begin
      cfg   = evCfg[e];
      hitSh = gatedHit >> cfg.matchSel;
      mHit  = hitSh[0];
      ioSh  = ioAll >> cfg.ioSel;
      ioOk  = (ioSh[0] == cfg.ioLevel);
      smSh  = cfg.stateMask >> stateQ;
      case (cfg.dirQual)
        DIR_UP:   dirOk = !countDown;
        DIR_DOWN: dirOk = countDown;
        default:  dirOk = 1'b1;
      endcase
      qual   = smSh[0] && dirOk;
      holdOn = cfg.holdMatch && (cfg.mode == MODE_AND);
      anyHit = mHit || (holdOn && pendQ[e]);
      case (cfg.mode)
        MODE_MATCH: cond = mHit;
        MODE_IO:    cond = ioOk;
        MODE_AND:   cond = anyHit && ioOk;
        default:    cond = mHit || ioOk;
      endcase
      fired[e] = cond && qual;
      pendD[e] = holdOn && !fired[e] && (pendQ[e] || (mHit && qual));
      unusedSpare = unusedSpare ^ (^{cfg.spare0, cfg.spare1, cfg.nextState});
    end
  end

  assign haltFire  = |(fired & haltMask);
  assign stopFire  = |(fired & stopMask);
  assign startFire = |(fired & startMask);

  // lowest-numbered loading event wins
  always_comb begin
    stateNext = stateQ;
    loadAny   = 1'b0;
    for (int e = NUM_EVENTS - 1; e >= 0; e--)
      if (fired[e] && evCfg[e].loadState) begin
        stateNext = evCfg[e].nextState[STATE_W-1:0];
        loadAny   = 1'b1;
      end
  end

  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      setHit[o] = |(fired & setMask[o]);
      clrHit[o] = |(fired & clrMask[o]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltQ <= 1'b0; stopQ <= 1'b1;
      stateQ <= '0; pendQ <= '0; ioOutQ <= '0;
      irq <= 1'b0; dmaReq <= 1'b0;
    end else begin
      pendQ  <= pendD;
      irq    <= |(fired & irqMask);
      dmaReq <= |(fired & dmaMask);
      if (wrCtrl) begin
        haltQ <= cfgData[2];
        stopQ <= cfgData[3];
      end else if (haltFire) haltQ <= 1'b1;
      else if (stopFire)     stopQ <= 1'b1;
      else if (startFire)    stopQ <= 1'b0;
      if (wrState)      stateQ <= cfgData[STATE_W-1:0];
      else if (loadAny) stateQ <= stateNext;
      for (int o = 0; o < NUM_OUT; o++) begin
        if (setHit[o] && clrHit[o]) ioOutQ[o] <= ~ioOutQ[o];
        else if (setHit[o])         ioOutQ[o] <= 1'b1;
        else if (clrHit[o])         ioOutQ[o] <= 1'b0;
      end
    end
  end

  assign strb.clearCnt  = wrCtrl && cfgData[4];
  assign strb.run       = runNow;
  assign strb.upDown    = upDownQ;
  assign strb.autoLimit = autoLimQ;
  assign strb.limitEv   = |(fired & limitMask);
  assign matchVals      = matchQ;
  assign ioOut          = ioOutQ;
  assign stateOut       = stateQ;

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (haltQ && !wrCtrl) |=> haltQ);

  // R11
  stop_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stopQ) |-> $past(stopFire || wrCtrl));

  // R12
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fired == '0) |=> $stable(ioOutQ));

  // R13
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(|(fired & irqMask)));

endmodule

// File: rtl/sevt_timer.sv
module sevt_timer
  import sevt_pkg::*;
#(
  parameter int NUM_EVENTS = 4,
  parameter int NUM_MATCH  = 4,
  parameter int NUM_IN     = 4,
  parameter int NUM_OUT    = 4,
  parameter int CNT_W      = 16,
  parameter int STATE_W    = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWe,
  input  logic [7:0]         cfgAddr,
  input  logic [31:0]        cfgData,
  input  logic [NUM_IN-1:0]  ioIn,
  output logic [NUM_OUT-1:0] ioOut,
  output logic               irq,
  output logic               dmaReq,
  output logic [CNT_W-1:0]   count,
  output logic               countDown,
  output logic [STATE_W-1:0] stateOut
);

  cntStrobe_t strb;
  logic [NUM_MATCH-1:0][CNT_W-1:0] matchVals;
  logic [NUM_MATCH-1:0] matchHit;

  sevt_ctrl #(
    .NUM_EVENTS(NUM_EVENTS), .NUM_MATCH(NUM_MATCH), .NUM_IN(NUM_IN),
    .NUM_OUT(NUM_OUT), .CNT_W(CNT_W), .STATE_W(STATE_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .ioIn(ioIn), .countDown(countDown), .matchHit(matchHit), .strb(strb),
    .matchVals(matchVals), .ioOut(ioOut), .irq(irq), .dmaReq(dmaReq),
    .stateOut(stateOut)
  );

  sevt_datapath #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .matchVals(matchVals),
    .matchHit(matchHit), .count(count), .countDown(countDown)
  );

endmodule

// File: tb/sevt_timer_tb_top.sv
module sevt_timer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [3:0]  ioIn = '0;
  logic [3:0]  ioOut;
  logic        irq, dmaReq, countDown;
  logic [15:0] count;
  logic [1:0]  stateOut;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sevt_timer dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .ioIn(ioIn), .ioOut(ioOut), .irq(irq), .dmaReq(dmaReq), .count(count),
    .countDown(countDown), .stateOut(stateOut)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0; cfgWe = 1'b0; ioIn = '0;
    step(3);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfgAddr = a; cfgData = d; cfgWe = 1'b1;
    step(1);
    cfgWe = 1'b0;
  endtask

  // start counter from zero: clear strobe plus mode bits, stop and halt low
  task automatic go(input logic [31:0] modeBits);
    wr(8'h00, modeBits | 32'h10);
  endtask

  function automatic logic [31:0] mk(input int msel, input int iosel, input int lvl,
      input int mode, input int dir, input int hold, input int ld, input int nxt,
      input int smask);
    mk = (32'(smask) << 24) | (32'(nxt) << 16) | (32'(ld) << 14) | (32'(hold) << 13)
       | (32'(dir) << 11) | (32'(mode) << 9) | (32'(lvl) << 8) | (32'(iosel) << 4)
       | 32'(msel);
  endfunction

  task automatic testReset();
    doReset();
    chk("R1 count", int'(count), 0);
    chk("R1 outputs", int'(ioOut), 0);
    chk("R1 state", int'(stateOut), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 dma", int'(dmaReq), 0);
    step(5);
    chk("R1 stopped", int'(count), 0);
  endtask

  task automatic testUpAuto();
    doReset();
    wr(8'h10, 5);
    go(32'h2);
    for (int t = 0; t < 12; t++) begin
      chk("R2 wrap", int'(count), t % 6);
      step(1);
    end
    chk("R2 dir", int'(countDown), 0);
  endtask

  task automatic testUpDown();
    int expv[6] = '{0, 1, 2, 3, 2, 1};
    doReset();
    wr(8'h10, 3);
    go(32'h3);
    for (int t = 0; t < 12; t++) begin
      chk("R3 seq", int'(count), expv[t % 6]);
      if (t % 6 == 4) chk("R3 down", int'(countDown), 1);
      if (t % 6 == 1) chk("R3 up", int'(countDown), 0);
      step(1);
    end
  endtask

  task automatic testLimitEvent();
    doReset();
    wr(8'h10, 2);  // ignored: automatic limit off
    wr(8'h12, 4);
    wr(8'h20, mk(2, 0, 0, 0, 0, 0, 0, 0, 8'hFF));
    wr(8'h02, 1);
    wr(8'h07, 1);
    go(32'h0);
    for (int t = 0; t < 10; t++) begin
      chk("R4 limit", int'(count), t % 5);
      if (t == 5) chk("R13 dma", int'(dmaReq), 1);
      if (t == 6) chk("R13 dma end", int'(dmaReq), 0);
      step(1);
    end
  endtask

  task automatic testStateGate();
    doReset();
    wr(8'h10, 7);
    wr(8'h11, 2);
    wr(8'h20, mk(1, 0, 0, 0, 0, 0, 1, 2, 8'h02));
    wr(8'h30, 32'h1);
    go(32'h2);
    step(10);
    chk("R5 gated off", int'(ioOut[0]), 0);
    wr(8'h01, 1);
    step(10);
    chk("R5 fired in state", int'(ioOut[0]), 1);
    chk("R5 state load", int'(stateOut), 2);
  endtask

  task automatic testLowestWins();
    doReset();
    wr(8'h20, mk(0, 0, 1, 1, 0, 0, 1, 2, 8'hFF));
    wr(8'h21, mk(0, 0, 1, 1, 0, 0, 1, 3, 8'hFF));
    wr(8'h22, mk(0, 0, 1, 1, 0, 0, 1, 1, 8'hFF));
    ioIn[0] = 1'b1;
    step(2);
    chk("R6 lowest", int'(stateOut), 2);
  endtask

  task automatic dirRun(input int dir, input int expPulses);
    int pulses = 0;
    doReset();
    wr(8'h10, 3);
    wr(8'h11, 2);
    wr(8'h20, mk(1, 0, 0, 0, dir, 0, 0, 0, 8'hFF));
    wr(8'h06, 1);
    go(32'h3);
    for (int t = 0; t < 12; t++) begin
      pulses += int'(irq);
      step(1);
    end
    chk("R7 direction pulses", pulses, expPulses);
  endtask

  task automatic testDirection();
    dirRun(2, 2);
    dirRun(0, 4);
    dirRun(1, 2);
  endtask

  task automatic countIrq(output int pulses);
    pulses = 0;
    for (int t = 0; t < 16; t++) begin
      pulses += int'(irq);
      step(1);
    end
  endtask

  task automatic testCombine();
    int p;
    doReset();
    wr(8'h10, 7);
    wr(8'h11, 3);
    wr(8'h20, mk(1, 0, 1, 2, 0, 0, 0, 0, 8'hFF));
    wr(8'h06, 1);
    go(32'h2);
    step(2);
    countIrq(p);
    chk("R8 and io low", p, 0);
    ioIn[0] = 1'b1;
    step(2);
    countIrq(p);
    chk("R8 and io high", p, 2);
    ioIn[0] = 1'b0;
    step(2);
    wr(8'h20, mk(1, 0, 1, 3, 0, 0, 0, 0, 8'hFF));
    step(1);
    countIrq(p);
    chk("R8 or match only", p, 2);
    ioIn[0] = 1'b1;
    step(2);
    countIrq(p);
    chk("R8 or io high", p, 16);
    ioIn[0] = 1'b0;
  endtask

  task automatic holdRun(input int hold);
    doReset();
    wr(8'h10, 15);
    wr(8'h11, 2);
    wr(8'h20, mk(1, 0, 1, 2, 0, hold, 0, 0, 8'hFF));
    wr(8'h06, 1);
    go(32'h2);
    for (int t = 0; t < 8; t++) begin
      if (t == 3) chk("R9 no early fire", int'(irq), 0);
      if (t == 6) chk("R9 held fire", int'(irq), hold);
      if (t == 7) chk("R9 single fire", int'(irq), 0);
      if (t == 5) ioIn[0] = 1'b1;
      step(1);
    end
    ioIn[0] = 1'b0;
  endtask

  task automatic testHold();
    holdRun(1);
    holdRun(0);
  endtask

  task automatic testHalt();
    doReset();
    wr(8'h20, mk(0, 0, 1, 1, 0, 0, 0, 0, 8'hFF));
    wr(8'h21, mk(0, 1, 1, 1, 0, 0, 0, 0, 8'hFF));
    wr(8'h03, 1);
    wr(8'h04, 1);
    wr(8'h05, 3);
    go(32'h0);
    step(3);
    ioIn[0] = 1'b1;
    step(1);
    ioIn[0] = 1'b0;
    step(3);
    chk("R10 halted", int'(count), 4);
    ioIn[1] = 1'b1;
    step(3);
    chk("R10 start ignored", int'(count), 4);
    wr(8'h00, 32'h0);
    step(3);
    chk("R10 cleared by write", int'(count), 7);
    ioIn[1] = 1'b0;
  endtask

  task automatic testStopStart();
    int c;
    doReset();
    wr(8'h11, 4);
    wr(8'h20, mk(1, 0, 0, 0, 0, 0, 0, 0, 8'hFF));
    wr(8'h21, mk(0, 1, 1, 1, 0, 0, 0, 0, 8'hFF));
    wr(8'h22, mk(0, 2, 1, 1, 0, 0, 0, 0, 8'hFF));
    wr(8'h04, 32'h5);
    wr(8'h05, 32'h6);
    go(32'h0);
    step(8);
    chk("R11 stopped", int'(count), 5);
    ioIn[1] = 1'b1;
    step(3);
    chk("R11 restarted", int'(count), 7);
    c = int'(count);
    ioIn[2] = 1'b1;
    step(3);
    chk("R11 stop beats start", int'(count), c + 1);
    ioIn = '0;
  endtask

  task automatic testOutputs();
    doReset();
    wr(8'h20, mk(0, 0, 1, 1, 0, 0, 0, 0, 8'hFF));
    wr(8'h30, 32'h0000_0001);
    wr(8'h31, 32'h0001_0001);
    ioIn[0] = 1'b1;
    chk("R12 toggle start", int'(ioOut[1]), 0);
    step(1);
    chk("R12 toggle 1", int'(ioOut[1]), 1);
    chk("R12 set", int'(ioOut[0]), 1);
    step(1);
    chk("R12 toggle 2", int'(ioOut[1]), 0);
    step(1);
    chk("R12 toggle 3", int'(ioOut[1]), 1);
    ioIn[0] = 1'b0;
    step(1);
    chk("R12 hold value", int'(ioOut[1]), 1);
    chk("R12 set holds", int'(ioOut[0]), 1);
    wr(8'h32, 32'h0001_0000);
    wr(8'h20, mk(0, 0, 0, 1, 0, 0, 0, 0, 8'hFF));
    wr(8'h30, 32'h0001_0000);
    step(1);
    chk("R12 clear", int'(ioOut[0]), 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    testReset();
    testUpAuto();
    testUpDown();
    testLimitEvent();
    testStateGate();
    testLowestWins();
    testDirection();
    testCombine();
    testHold();
    testHalt();
    testStopStart();
    testOutputs();
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule